// File: doc/BRIEF.md
# Ternary Layer Match Slot

This block is a single layer slot of an associative pattern memory. It keeps one stored position word. The twelve upper positions of that word must match exactly. The three lowest positions are ternary: each one can require a 0, require a 1, or accept either value. Hit words arrive on a shared broadcast bus, qualified by a valid strobe. The slot compares each accepted hit with its stored word. When every position agrees, it sets a sticky match flag, which stays set until the next event-initialise pulse.

Comparison is split into two stages to limit switching activity. In the first cycle only the four lowest hit bits are checked. These are the three ternary positions plus the lowest exact bit. The upper eleven bits are loaded into a register and compared on the next cycle, and only when that pre-match passed. As a result the slot takes at most one hit every two cycles, and it shows this on `hit_ready`.

A write port loads the exact bits and the ternary pairs. A write is accepted only while the hit bus is idle and no comparison is in flight.

Top module: `tcam_layer_slot`

## Requirements
- R1: After reset, `match_flag` is 0 and `hit_ready` is 1. Every ternary pair resets to 10 (never-match), so no hit matches until a word is written.
- R2: Hit bits 14..3 must equal stored exact bits 11..0; hit bit 3 corresponds to exact bit 0.
- R3: Ternary position i (i = 0..2) compares hit bit i with pair bits [2i+1:2i] of `wr_tern`. Pair 00 accepts only 0, 01 accepts only 1, 11 accepts either value, and 10 accepts neither.
- R4: A hit is accepted on a clock edge where `hit_valid` and `hit_ready` are both high. Its full match shows on `match_flag` after the second rising edge counting from that acceptance edge. The upper bits are compared only when hit bits 3..0 pass.
- R5: After an accepted hit, `hit_ready` is low for exactly one cycle. A `hit_valid` during that cycle is ignored.
- R6: Once `match_flag` is set, it stays set through later non-matching hits until `evt_init` is asserted.
- R7: `evt_init` clears `match_flag` on the next edge. It takes priority over a match completing on the same edge.
- R8: `wr_en` is ignored while `hit_valid` is high or `hit_ready` is low. In that case the stored word stays unchanged.
- R9: With all three ternary pairs at 11, all eight values of hit bits 2..0 match the same stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load the stored word |
| wr_exact | input | 12 | Exact bits of the stored word |
| wr_tern | input | 6 | Three ternary pairs, pair i at bits [2i+1:2i] |
| hit_valid | input | 1 | Hit word on the bus is valid |
| hit_word | input | 15 | Broadcast hit position |
| hit_ready | output | 1 | Slot can accept a hit this cycle |
| evt_init | input | 1 | Clear the per-event match flag |
| match_flag | output | 1 | Sticky per-event match |

## Verification
The bench drives a hit that fails only in the upper bits. If a design let the pre-match alone set the flag, the flag would be set wrongly. It offers a matching hit during the busy cycle; a design that ignored `hit_ready` would accept that hit and set the flag. It issues writes together with a hit and during the busy cycle. A design that let those writes through would start matching the new word. It also raises `evt_init` on the same edge that a match completes, where a design with the wrong priority would leave the flag set. Random words with random ternary pairs cover every pair code, including the never-match code 10 and the fully widened window.

// File: rtl/tcam_layer_slot.sv
module tcam_layer_slot #(
  parameter int EXACT_W = 12,
  parameter int TERN_N  = 3,
  parameter int PRE_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [EXACT_W-1:0]    wr_exact,
  input  logic [2*TERN_N-1:0]   wr_tern,
  input  logic                  hit_valid,
  input  logic [EXACT_W+TERN_N-1:0] hit_word,
  output logic                  hit_ready,
  input  logic                  evt_init,
  output logic                  match_flag
);
  localparam int HIT_W  = EXACT_W + TERN_N;
  localparam int PAIR_W = 2 * TERN_N;
  localparam int HI_W   = HIT_W - PRE_W;
  localparam int PRE_EX = PRE_W - TERN_N;

  logic [EXACT_W-1:0] ex_q;
  logic [PAIR_W-1:0]  tp_q;
  logic [HI_W-1:0]    hi_q;
  logic               busy_q, pre_q, flag_q;
  logic [TERN_N-1:0]  tern_ok;

  for (genvar i = 0; i < TERN_N; i++) begin : g_tern
    assign tern_ok[i] = (tp_q[2*i+1:2*i] == 2'b11) ||
                        (tp_q[2*i+1:2*i] == {1'b0, hit_word[i]});
  end

  wire accept = hit_valid && !busy_q;
  wire pre_ok = (&tern_ok) && (hit_word[PRE_W-1:TERN_N] == ex_q[PRE_EX-1:0]);
  wire hi_eq  = (hi_q == ex_q[EXACT_W-1:PRE_EX]);
  wire set_m  = busy_q && pre_q && hi_eq;
  wire wr_ok  = wr_en && !hit_valid && !busy_q;

  assign hit_ready  = !busy_q;
  assign match_flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q   <= '0;
      tp_q   <= {TERN_N{2'b10}};
      hi_q   <= '0;
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        ex_q <= wr_exact;
        tp_q <= wr_tern;
      end
      busy_q <= accept;
      pre_q  <= accept && pre_ok;
      if (accept && pre_ok) hi_q <= hit_word[HIT_W-1:PRE_W];
      if (evt_init)   flag_q <= 1'b0;
      else if (set_m) flag_q <= 1'b1;
    end
  end

  // R5
  busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> !hit_ready);

  // R7
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_init |=> !match_flag);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_flag) |-> $past(evt_init));

  // R4
  two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(!hit_ready));

  // R8
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid || !hit_ready) |=> ($stable(ex_q) && $stable(tp_q)));
endmodule

// File: tb/tcam_layer_slot_tb_top.sv
module tcam_layer_slot_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, hit_valid = 0, evt_init = 0;
  logic [11:0] wr_exact = 0;
  logic [5:0]  wr_tern = 0;
  logic [14:0] hit_word = 0;
  logic hit_ready, match_flag;
  int n_chk = 0, n_bad = 0;
  logic [11:0] m_ex;
  logic [5:0]  m_tp;
  logic        m_flag;

  always #4 clk = ~clk;

  tcam_layer_slot dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_exact(wr_exact),
    .wr_tern(wr_tern), .hit_valid(hit_valid), .hit_word(hit_word), .hit_ready(hit_ready),
    .evt_init(evt_init), .match_flag(match_flag));

  function automatic logic ref_match(logic [11:0] ex, logic [5:0] tp, logic [14:0] h);
    logic ok = (h[14:3] == ex);
    for (int i = 0; i < 3; i++) begin
      case (tp[2*i +: 2])
        2'b00: ok &= (h[i] == 1'b0);
        2'b01: ok &= (h[i] == 1'b1);
        2'b11: ok &= 1'b1;
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_word(logic [11:0] ex, logic [5:0] tp);
    wr_en = 1; wr_exact = ex; wr_tern = tp;
    @(negedge clk);
    wr_en = 0;
    m_ex = ex; m_tp = tp;
  endtask

  task automatic do_hit(logic [14:0] h, string req);
    hit_valid = 1; hit_word = h;
    @(negedge clk);
    hit_valid = 0;
    check("R5", hit_ready, 1'b0);
    @(negedge clk);
    m_flag = m_flag | ref_match(m_ex, m_tp, h);
    check(req, match_flag, m_flag);
    check("R5", hit_ready, 1'b1);
  endtask

  task automatic do_init();
    evt_init = 1;
    @(negedge clk);
    evt_init = 0;
    m_flag = 0;
    check("R7", match_flag, 1'b0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    m_ex = 0; m_tp = 6'b101010; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", match_flag, 1'b0);
    check("R1", hit_ready, 1'b1);
    do_hit(15'h0000, "R1");
    do_hit(15'h0007, "R1");

    // R2/R3 exact plus specific pairs: pair0=01, pair1=00, pair2=11
    write_word(12'hA5C, 6'b110001);
    do_hit({12'hA5C, 3'b001}, "R3");
    do_init();
    do_hit({12'hA5C, 3'b101}, "R3");
    do_init();
    do_hit({12'hA5C, 3'b000}, "R3");
    do_hit({12'hA5C, 3'b011}, "R3");
    // R4: low bits pass, upper bits differ
    do_hit({12'hA5C ^ 12'h800, 3'b001}, "R4");
    // R2: bit 3 of hit maps to exact bit 0
    do_hit({12'hA5D, 3'b001}, "R2");
    check("R2", match_flag, 1'b0);
    // R6 sticky
    do_hit({12'hA5C, 3'b101}, "R6");
    do_hit({12'h123, 3'b000}, "R6");
    check("R6", match_flag, 1'b1);
    do_init();

    // R9 window of 8
    write_word(12'h3F1, 6'b111111);
    for (int v = 0; v < 8; v++) begin
      do_hit({12'h3F1, v[2:0]}, "R9");
      check("R9", match_flag, 1'b1);
      do_init();
    end

    // R5: matching hit offered while busy is ignored
    hit_valid = 1; hit_word = {12'h3F0, 3'b000};
    @(negedge clk);
    hit_word = {12'h3F1, 3'b010};
    @(negedge clk);
    hit_valid = 0;
    check("R5", hit_ready, 1'b1);
    check("R5", match_flag, 1'b0);
    @(negedge clk);
    check("R5", match_flag, 1'b0);

    // R7: init on the edge a match completes
    hit_valid = 1; hit_word = {12'h3F1, 3'b100};
    @(negedge clk);
    hit_valid = 0; evt_init = 1;
    @(negedge clk);
    evt_init = 0;
    check("R7", match_flag, 1'b0);

    // R8: write with hit_valid high, then write during busy cycle
    hit_valid = 1; hit_word = {12'h000, 3'b000};
    wr_en = 1; wr_exact = 12'h777; wr_tern = 6'b000000;
    @(negedge clk);
    hit_valid = 0;
    @(negedge clk);
    wr_en = 0;
    check("R8", match_flag, 1'b0);
    do_hit({12'h777, 3'b000}, "R8");
    check("R8", match_flag, 1'b0);
    do_hit({12'h3F1, 3'b110}, "R8");
    check("R8", match_flag, 1'b1);
    do_init();

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [11:0] ex;
      logic [5:0] tp;
      ex = 12'($urandom);
      tp = 6'($urandom);
      write_word(ex, tp);
      if ($urandom_range(0, 3) == 0) do_init();
      for (int k = 0; k < 4; k++) begin
        logic [14:0] h;
        h = {ex, 3'($urandom)};
        if ($urandom_range(0, 2) == 0) h[14:3] ^= 12'(1 << $urandom_range(0, 11));
        do_hit(h, "R4");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule